// File: doc/BRIEF.md
# Grid Multiplex Serial Sequencer for a Fluorescent Display Driver

This block keeps a multiplexed vacuum-fluorescent display alive by feeding an external column/grid driver over three wires: serial data, shift clock and a load strobe. Time is cut into fixed timeslots of `SLOT_CYC` clock cycles, one per grid. While one grid is lit, the block shifts out the bit pattern for the following grid, then pulses the load strobe so the driver latches it; the grid counter advances at the slot boundary and wraps after `N_GRID` grids, which makes one full multiplex cycle.

Each serial bit position k draws its value from word k of an output map of `MAP_WORDS` words, each `MAP_W` bits wide; the bit chosen inside the word is the number of the grid being prepared. A small register bank sets how many bits are sent per slot (the last bit index, clamped to `MAP_WORDS-1`), the polarity of the blanking output, and a test mode that forces every data bit to one and shortens the lit part of each slot from 15/16 to 7/16. Reading the test register returns a fixed identifier with the test flag in bit 0. Registers are written with a single-cycle strobe and read back combinationally; there is no flow control at either port, so every write is taken in the cycle its strobe is high.

Top module: `vfd_mux_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to slot cycle 0 of grid 0, sets the last-bit index to 0x79, clears polarity and test mode, and holds `vf_load` low.
- R2: A write to address 0x0E stores the data as the last-bit index M; any value above 0x79 (0x7A to 0xFF) stores 0x79. Reading 0x0E returns M.
- R3: Reading address 0x0F returns `{7'b0000011, test}`; reading 0x0C returns `{7'b0, pol}`; writes to 0x0F and 0x0C take bit 0 of the data.
- R4: A write to address 0x00 changes no register, as seen through the readbacks of 0x0C, 0x0E and 0x0F.
- R5: `grid_idx` stays constant for `SLOT_CYC` cycles, then advances by one, wrapping from `N_GRID-1` to 0.
- R6: In slot cycle t, `vf_sclk` is high exactly when t < 2(M+1) and t is odd; it gives M+1 pulses per slot and stays low otherwise.
- R7: For t < 2(M+1), outside test mode, `vf_data` equals bit g' of map word t/2 (integer division), where g' is the grid after `grid_idx`; it is therefore stable across each rising shift-clock edge. For t >= 2(M+1) `vf_data` is 0.
- R8: `vf_load` is high for exactly one cycle per slot, at t = 2(M+1).
- R9: The blank window is t >= SLOT_CYC*15/16 outside test mode; `vf_blank` is high in the window when `pol` is 1, and low in the window (high elsewhere) when `pol` is 0.
- R10: In test mode every bit shifted is 1 and the blank window starts at t = SLOT_CYC*7/16.
- R11: A new M takes effect from the next slot boundary; the slot in progress keeps its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (4 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational register read data |
| map_wr | input | 1 | Output map write strobe |
| map_addr | input | MAP_AW | Output map word address |
| map_wdata | input | MAP_W | Output map word data |
| vf_data | output | 1 | Serial data to display driver |
| vf_sclk | output | 1 | Shift clock to display driver |
| vf_load | output | 1 | Load strobe to display driver |
| vf_blank | output | 1 | Blanking output, polarity per register |
| grid_idx | output | GRID_W | Grid lit in the current slot |

## Verification
The stream is checked in every cycle of whole multiplex cycles for the full length (M = 0x79), a short length (M = 5), the single-bit case (M = 0) and clamped writes, so that an off-by-one in the pulse count, the load position or the clamp bound shows as a mismatch against arithmetic from the slot cycle. The map holds a word pattern that differs per position and per bit, so reading the lit grid instead of the next one, or the wrong word, changes the data. Both blank polarities and test mode on and off separate the two window starts and the inversion, and limit writes in mid-slot show whether the running slot keeps its length.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  localparam logic [7:0] A_NOP  = 8'h00;
  localparam logic [7:0] A_POL  = 8'h0C;
  localparam logic [7:0] A_LIM  = 8'h0E;
  localparam logic [7:0] A_TEST = 8'h0F;
  localparam logic [6:0] DEV_ID = 7'b0000011;
endpackage

// File: rtl/vfd_regs.sv
module vfd_regs
  import vfd_pkg::*;
#(
  parameter int MAX_LIM = 121
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic [7:0] lim,
  output logic       pol,
  output logic       test
);
  localparam logic [7:0] LIM_TOP = 8'(MAX_LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim  <= LIM_TOP;
      pol  <= 1'b0;
      test <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_LIM:   lim  <= (reg_wdata > LIM_TOP) ? LIM_TOP : reg_wdata;
        A_POL:   pol  <= reg_wdata[0];
        A_TEST:  test <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_LIM:   reg_rdata = lim;
      A_POL:   reg_rdata = {7'b0, pol};
      A_TEST:  reg_rdata = {DEV_ID, test};
      default: reg_rdata = 8'h00;
    endcase
  end

  // R2: stored index never exceeds the map range
  a_r2_lim_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    lim <= LIM_TOP);
  // R4: a no-op write leaves every register unchanged
  a_r4_nop_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_NOP) |=> ($stable(lim) && $stable(pol) && $stable(test)));
endmodule

// File: rtl/vfd_map.sv
module vfd_map #(
  parameter int MAP_WORDS = 122,
  parameter int MAP_W     = 7,
  parameter int GRID_W    = 2,
  localparam int MAP_AW   = $clog2(MAP_WORDS)
) (
  input  logic              clk,
  input  logic              map_wr,
  input  logic [MAP_AW-1:0] map_addr,
  input  logic [MAP_W-1:0]  map_wdata,
  input  logic [MAP_AW-1:0] rd_idx,
  input  logic [GRID_W-1:0] rd_grid,
  output logic              rd_bit
);
  logic [MAP_W-1:0] mem [MAP_WORDS];

  always_ff @(posedge clk) begin
    if (map_wr) mem[map_addr] <= map_wdata;
  end

  assign rd_bit = mem[rd_idx][rd_grid];
endmodule

// File: rtl/vfd_timing.sv
module vfd_timing #(
  parameter int N_GRID   = 4,
  parameter int SLOT_CYC = 400,
  parameter int MAP_AW   = 7,
  localparam int GRID_W  = (N_GRID > 1) ? $clog2(N_GRID) : 1,
  localparam int CNT_W   = $clog2(SLOT_CYC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        lim,
  input  logic              test,
  output logic [GRID_W-1:0] grid,
  output logic [GRID_W-1:0] next_grid,
  output logic [MAP_AW-1:0] bit_idx,
  output logic              shifting,
  output logic              sclk,
  output logic              load,
  output logic              blank_act
);
  localparam logic [CNT_W-1:0]  SLOT_LAST = CNT_W'(SLOT_CYC - 1);
  localparam logic [GRID_W-1:0] GRID_LAST = GRID_W'(N_GRID - 1);
  localparam logic [CNT_W-1:0]  LIT_NORM  = CNT_W'(SLOT_CYC * 15 / 16);
  localparam logic [CNT_W-1:0]  LIT_TEST  = CNT_W'(SLOT_CYC * 7 / 16);

  logic [CNT_W-1:0] cnt;
  logic [7:0]       lim_act;
  logic [CNT_W-1:0] shift_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      grid    <= '0;
      lim_act <= lim;
    end else if (cnt == SLOT_LAST) begin
      cnt     <= '0;
      grid    <= (grid == GRID_LAST) ? '0 : grid + 1'b1;
      lim_act <= lim;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign next_grid = (grid == GRID_LAST) ? '0 : grid + 1'b1;
  assign shift_end = CNT_W'({lim_act, 1'b0}) + CNT_W'(2);
  assign shifting  = cnt < shift_end;
  assign bit_idx   = cnt[MAP_AW:1];
  assign sclk      = shifting & cnt[0];
  assign load      = (cnt == shift_end);
  assign blank_act = cnt >= (test ? LIT_TEST : LIT_NORM);

  // R8: strobe lasts a single cycle
  a_r8_load_single: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load);
  // R6: no shift clock while the strobe is high
  a_r6_clk_off_at_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !sclk);
  // R5: grid steps by one with wrap at each slot boundary
  a_r5_grid_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == SLOT_LAST) |=> (grid == (($past(grid) == GRID_LAST) ? '0 : $past(grid) + 1'b1)));
  // R11: active length only changes at a slot boundary
  a_r11_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(lim_act));
  // R9: first slot cycle is always lit
  a_r9_lit_head: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !blank_act);
endmodule

// File: rtl/vfd_mux_seq.sv
module vfd_mux_seq
  import vfd_pkg::*;
#(
  parameter int N_GRID    = 4,
  parameter int SLOT_CYC  = 400,
  parameter int MAP_WORDS = 122,
  parameter int MAP_W     = 7,
  localparam int MAP_AW   = $clog2(MAP_WORDS),
  localparam int GRID_W   = (N_GRID > 1) ? $clog2(N_GRID) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              map_wr,
  input  logic [MAP_AW-1:0] map_addr,
  input  logic [MAP_W-1:0]  map_wdata,
  output logic              vf_data,
  output logic              vf_sclk,
  output logic              vf_load,
  output logic              vf_blank,
  output logic [GRID_W-1:0] grid_idx
);
  // Slot must hold the longest stream plus the strobe; grids index map bits.

  logic [7:0]        lim;
  logic              pol, test;
  logic [GRID_W-1:0] next_grid;
  logic [MAP_AW-1:0] bit_idx;
  logic              shifting, map_bit, blank_act;

  vfd_regs #(.MAX_LIM(MAP_WORDS - 1)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .lim, .pol, .test
  );

  vfd_timing #(.N_GRID(N_GRID), .SLOT_CYC(SLOT_CYC), .MAP_AW(MAP_AW)) u_timing (
    .clk, .rst_n, .lim, .test,
    .grid(grid_idx), .next_grid, .bit_idx, .shifting,
    .sclk(vf_sclk), .load(vf_load), .blank_act
  );

  vfd_map #(.MAP_WORDS(MAP_WORDS), .MAP_W(MAP_W), .GRID_W(GRID_W)) u_map (
    .clk, .map_wr, .map_addr, .map_wdata,
    .rd_idx(bit_idx), .rd_grid(next_grid), .rd_bit(map_bit)
  );

  assign vf_data  = shifting & (test | map_bit);
  assign vf_blank = pol ? blank_act : ~blank_act;

  // R10: test mode shifts only ones
  a_r10_test_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (test && vf_sclk) |-> vf_data);
  // R7: data idle low once the stream is over
  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    vf_load |-> !vf_data);
endmodule

// File: tb/test_vfd_mux_seq.sv
module test_vfd_mux_seq;
  localparam int CLK_P = 10;
  localparam int NG = 4;
  localparam int SLOT = 400;
  localparam int WORDS = 122;
  localparam int MW = 7;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, map_wr = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
  logic [6:0] map_addr = 0;
  logic [MW-1:0] map_wdata = 0;
  logic vf_data, vf_sclk, vf_load, vf_blank;
  logic [1:0] grid_idx;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit mon_on = 0;
  int e_lim, e_lim_act, e_pol, e_test;

  always #(CLK_P/2) clk = ~clk;

  vfd_mux_seq i_vfd_mux_seq (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .map_wr, .map_addr, .map_wdata,
    .vf_data, .vf_sclk, .vf_load, .vf_blank, .grid_idx
  );

  function automatic int pat(input int k);
    return ((k * 5 + 3) ^ (k >> 2)) & 8'h7F;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at cyc %0d", req, act, exp, cyc);
    end
  endtask

  // Spec model of register state and slot position
  always @(posedge clk) begin
    if (!rst_n) begin
      cyc <= 0; e_lim <= 121; e_lim_act <= 121; e_pol <= 0; e_test <= 0;
    end else begin
      cyc <= cyc + 1;
      if (reg_wr) begin
        if (reg_addr == 8'h0E) e_lim <= (reg_wdata > 121) ? 121 : int'(reg_wdata);
        if (reg_addr == 8'h0C) e_pol <= int'(reg_wdata[0]);
        if (reg_addr == 8'h0F) e_test <= int'(reg_wdata[0]);
      end
      if (cyc % SLOT == SLOT - 1) e_lim_act <= e_lim;
    end
  end

  // Per-cycle stream monitor
  always @(negedge clk) begin
    if (mon_on) begin
      int t, g, ng, send, lit, ex_sclk, ex_data, ex_blank;
      t = cyc % SLOT;
      g = (cyc / SLOT) % NG;
      ng = (g + 1) % NG;
      send = 2 * (e_lim_act + 1);
      lit = e_test ? SLOT * 7 / 16 : SLOT * 15 / 16;
      ex_sclk = (t < send && (t % 2) == 1) ? 1 : 0;
      ex_data = (t < send) ? (e_test ? 1 : ((pat(t / 2) >> ng) & 1)) : 0;
      ex_blank = (t >= lit) ? e_pol : 1 - e_pol;
      chk(grid_idx == g, "R5 grid", int'(grid_idx), g);
      chk(vf_sclk == ex_sclk, "R6 sclk", int'(vf_sclk), ex_sclk);
      chk(vf_load == (t == send), "R8/R11 load", int'(vf_load), int'(t == send));
      chk(vf_data == ex_data, e_test ? "R10 data" : "R7 data", int'(vf_data), ex_data);
      chk(vf_blank == ex_blank, e_test ? "R10 blank" : "R9 blank", int'(vf_blank), ex_blank);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string req);
    reg_addr = a; #1;
    chk(reg_rdata == exp, req, int'(reg_rdata), exp);
  endtask

  task automatic slots(input int n);
    repeat (n * SLOT) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int k = 0; k < WORDS; k++) begin
      map_wr = 1; map_addr = 7'(k); map_wdata = MW'(pat(k));
      @(negedge clk);
    end
    map_wr = 0;
    // R1 reset state
    chk(grid_idx == 0, "R1 grid", int'(grid_idx), 0);
    chk(vf_load == 0, "R1 load", int'(vf_load), 0);
    chk(vf_blank == 1, "R1 blank", int'(vf_blank), 1);
    rd(8'h0E, 8'h79, "R1 limit");
    rd(8'h0C, 0, "R1 polarity");
    rd(8'h0F, 8'h06, "R1 R3 id");
    @(negedge clk); rst_n = 1; mon_on = 1;
    slots(5);                                  // R6 R7 R8 full length
    wr(8'h0E, 8'd5);  rd(8'h0E, 5, "R2 store 5");
    slots(3);
    wr(8'h0E, 8'd0);  rd(8'h0E, 0, "R2 store 0");
    slots(2);
    wr(8'h0E, 8'h7A); rd(8'h0E, 8'h79, "R2 clamp 7A");
    wr(8'h0E, 8'h09); rd(8'h0E, 9, "R2 store 9");
    wr(8'h0E, 8'hFF); rd(8'h0E, 8'h79, "R2 clamp FF");
    wr(8'h0E, 8'h80); rd(8'h0E, 8'h79, "R2 clamp 80");
    wr(8'h0E, 8'h79); rd(8'h0E, 8'h79, "R2 store 79");
    slots(2);
    wr(8'h0E, 8'd9);
    slots(1);
    wr(8'h00, 8'h55);                          // R4 no-op
    rd(8'h0E, 9, "R4 limit kept");
    rd(8'h0C, 0, "R4 polarity kept");
    rd(8'h0F, 8'h06, "R4 test kept");
    wr(8'h0C, 8'h01); rd(8'h0C, 1, "R3 polarity");
    slots(2);
    wr(8'h0F, 8'h01); rd(8'h0F, 8'h07, "R3 test set");
    slots(2);
    wr(8'h0C, 8'h00);
    slots(1);
    wr(8'h0F, 8'h00); rd(8'h0F, 8'h06, "R3 test clear");
    wr(8'h0E, 8'd3);                           // R11 mid-slot change
    slots(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule